// File: doc/BRIEF.md
# Shared-Period Four-Channel PWM Timer

This block produces four pulse-width-modulated outputs from a single up-counter. A programmable prescaler divides the input clock into count ticks. The counter climbs from zero to a programmable period value and then wraps back to zero. That wrap is the period event. Every output goes high at the period event. Each channel goes low when the counter reaches that channel's own compare value.

A write-only register port loads the following settings:

- the prescaler, together with the halt and clear controls;
- the period;
- four compare values;
- a two-bit collision rule per channel, which decides the level when a set and a clear land on the same tick;
- a per-channel option that takes the clear from the period event instead of the compare match.

Period and compare writes go to shadow copies. These copies become active only at the next wrap, or at a clear command, so a period in progress is never disturbed. Software gets 0% duty by routing a channel's clear to the period event with the "low" collision rule. It gets 100% duty with a compare value at or above the period.

Register map, with the address on `wr_addr` and the payload on `wr_data`:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 is halt (stored), bit 1 is clear (one-shot, not stored), bits 8:2 are the prescaler |
| 1 | Period |
| 2 + n | Compare value for channel n |
| 6 | Collision rules: bits 2n+1:2n belong to channel n |
| 7 | Clear-source select: bit n routes channel n's clear to the period event |

Top module: `pwm_quad_timer`

## Requirements
- R1: After reset the counter is halted, all registers are zero and all outputs are low. Outputs stay low until the control register clears the halt bit.
- R2: Each period lasts period+1 ticks. On the wrap the counter goes from the period value to zero, and every channel is set at that moment. No output ever rises on any other tick.
- R3: With a compare value c below the period and the default clear source, channel n is high for exactly c ticks per period. It is cleared on the tick where the counter becomes c.
- R4: A compare value equal to or greater than the period never clears. The channel is high for the whole period.
- R5: Ticks occur once every prescaler+1 clocks. The counter does not move between ticks.
- R6: When set and clear for channel n fall on the same tick, the code in bits 2n+1:2n of register 6 decides the level. 01 drives high, 10 drives low, and 00 or 11 keeps the previous level. With the default clear source this happens when the compare value is 0.
- R7: When bit n of register 7 is 1, channel n is cleared by the period event instead of its compare match. With code 10 the output is then constantly low, and with code 01 it is constantly high.
- R8: Period and compare writes are held in shadow registers. They become active only at the next wrap or clear, so the period in progress keeps its old pulse width.
- R9: While halted, the counter and all outputs hold their values.
- R10: Writing control with bit 1 set zeroes the counter and the prescaler phase, drives every output low on the next clock, and loads the shadow values into the active registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | PWM outputs, channel n on bit n |

## Verification
The counter and the active compare and period copies are not visible at the ports, so a wrong value in them shows up only as a changed high time or a changed repetition length on `pwm_out`.

- A counter that skips a value or wraps late makes every channel's window one prescaled tick too long or too short. This is detectable within a single period.
- A compare value that reloads too early changes the width of the period in progress rather than the next one.
- A wrong collision rule flips the whole level of a 0% or 100% channel at its first wrap.

The bench therefore measures high time over exact period windows, and it times the reload relative to an observed rising edge.

// File: rtl/pwm_quad_timer.sv
module pwm_quad_timer #(
  parameter int CH = 4,
  parameter int CW = 16,
  parameter int PW = 7,
  localparam int AW = $clog2(CH + 4),
  localparam int DW = (CW > PW + 2) ? ((CW > 2 * CH) ? CW : 2 * CH)
                                    : ((PW + 2 > 2 * CH) ? PW + 2 : 2 * CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [CH-1:0] pwm_out
);

  localparam int A_CTRL = 0;
  localparam int A_PER  = 1;
  localparam int A_CMP0 = 2;
  localparam int A_RES  = CH + 2;
  localparam int A_SEL  = CH + 3;

  logic          halt_q;
  logic [PW-1:0] pre_q, pdiv_q;
  logic [CW-1:0] cnt_q, per_sh, per_act;
  logic [CW-1:0] cmp_sh  [CH];
  logic [CW-1:0] cmp_act [CH];
  logic [2*CH-1:0] res_q;
  logic [CH-1:0] sel_q, out_q, out_nx;

  wire ctl_wr  = wr_en && (wr_addr == AW'(A_CTRL));
  wire clr_cmd = ctl_wr && wr_data[1];
  wire tick    = !halt_q && (pdiv_q >= pre_q);
  wire wrap    = tick && (cnt_q == per_act);
  wire [CW-1:0] cnt_nx = wrap ? '0 : cnt_q + 1'b1;
  wire [CW-1:0] per_nx = wrap ? per_sh : per_act;

  always_comb begin
    for (int n = 0; n < CH; n++) begin
      logic [CW-1:0] c;
      logic ce, cl;
      c  = wrap ? cmp_sh[n] : cmp_act[n];
      ce = tick && (cnt_nx == c) && (c < per_nx);
      cl = sel_q[n] ? wrap : ce;
      out_nx[n] = out_q[n];
      if (wrap && cl) begin
        case (res_q[2*n +: 2])
          2'b01:   out_nx[n] = 1'b1;
          2'b10:   out_nx[n] = 1'b0;
          default: out_nx[n] = out_q[n];
        endcase
      end else if (wrap) begin
        out_nx[n] = 1'b1;
      end else if (cl) begin
        out_nx[n] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b1;
      pre_q   <= '0;
      per_sh  <= '0;
      res_q   <= '0;
      sel_q   <= '0;
      for (int n = 0; n < CH; n++) cmp_sh[n] <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) begin
        halt_q <= wr_data[0];
        pre_q  <= wr_data[PW+1:2];
      end
      if (wr_addr == AW'(A_PER)) per_sh <= wr_data[CW-1:0];
      if (wr_addr == AW'(A_RES)) res_q  <= wr_data[2*CH-1:0];
      if (wr_addr == AW'(A_SEL)) sel_q  <= wr_data[CH-1:0];
      for (int n = 0; n < CH; n++)
        if (wr_addr == AW'(A_CMP0 + n)) cmp_sh[n] <= wr_data[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdiv_q  <= '0;
      cnt_q   <= '0;
      per_act <= '0;
      out_q   <= '0;
      for (int n = 0; n < CH; n++) cmp_act[n] <= '0;
    end else if (clr_cmd) begin
      pdiv_q  <= '0;
      cnt_q   <= '0;
      per_act <= per_sh;
      out_q   <= '0;
      for (int n = 0; n < CH; n++) cmp_act[n] <= cmp_sh[n];
    end else begin
      if (tick) begin
        pdiv_q <= '0;
        cnt_q  <= cnt_nx;
      end else if (!halt_q) begin
        pdiv_q <= pdiv_q + 1'b1;
      end
      if (wrap) begin
        per_act <= per_sh;
        for (int n = 0; n < CH; n++) cmp_act[n] <= cmp_sh[n];
      end
      out_q <= out_nx;
    end
  end

  assign pwm_out = out_q;

endmodule

// File: rtl/pwm_quad_timer_chk.sv
module pwm_quad_timer_chk #(
  parameter int CH = 4,
  parameter int CW = 16,
  parameter int PW = 7,
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [CH-1:0] pwm_out,
  input logic          halt_q,
  input logic [PW-1:0] pre_q,
  input logic [PW-1:0] pdiv_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] per_act
);

  wire clr_w   = wr_en && (wr_addr == '0) && wr_data[1];
  wire at_wrap = !halt_q && (pdiv_q >= pre_q) && (cnt_q == per_act);

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (pwm_out == '0 && cnt_q == '0));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !clr_w) |=> ($stable(pwm_out) && $stable(cnt_q)));

  // R5
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && pdiv_q < pre_q) |=> $stable(cnt_q));

  // R2
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_act);

  // R2
  rise_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_w && !at_wrap) |=> ((pwm_out & ~$past(pwm_out)) == '0));

endmodule

bind pwm_quad_timer pwm_quad_timer_chk #(.CH(CH), .CW(CW), .PW(PW), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pwm_out(pwm_out), .halt_q(halt_q), .pre_q(pre_q), .pdiv_q(pdiv_q),
  .cnt_q(cnt_q), .per_act(per_act)
);

// File: tb/pwm_quad_timer_test.sv
`timescale 1ns/1ps
module pwm_quad_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pwm_quad_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  typedef struct packed {
    int pre; int per; int c0; int c1; int c2; int c3;
    int codes; int sel; int e0; int e1; int e2; int e3;
  } vec_t;

  // R3 R4 R5 R6 R7: expected high clocks per period window (per+1)*(pre+1)
  localparam vec_t VEC [5] = '{
    '{0, 9, 2, 5, 0, 9,  'h55, 'h0, 2, 5, 10, 10},
    '{2, 7, 1, 3, 0, 12, 'h00, 'h0, 3, 9, 0, 24},
    '{1, 4, 2, 2, 2, 2,  'h59, 'h6, 4, 0, 10, 4},
    '{0, 3, 3, 4, 1, 0,  'hAA, 'h0, 4, 4, 1, 0},
    '{3, 5, 0, 0, 5, 3,  'hFF, 'h2, 0, 0, 24, 12}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(int pre, int per, int c0, int c1, int c2, int c3, int codes, int sel);
    wr(0, (pre << 2) | 3);
    wr(1, per);
    wr(2, c0); wr(3, c1); wr(4, c2); wr(5, c3);
    wr(6, codes); wr(7, sel);
    wr(0, (pre << 2) | 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi [4];
    int run1, run2;
    logic [3:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", int'(pwm_out), 0);
    repeat (20) @(negedge clk);
    chk("R1 halted after reset", int'(pwm_out), 0);

    foreach (VEC[v]) begin
      int win;
      win = (VEC[v].per + 1) * (VEC[v].pre + 1);
      setup(VEC[v].pre, VEC[v].per, VEC[v].c0, VEC[v].c1, VEC[v].c2, VEC[v].c3,
            VEC[v].codes, VEC[v].sel);
      repeat (3 * win + 2) @(negedge clk);
      for (int i = 0; i < 4; i++) hi[i] = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        for (int i = 0; i < 4; i++) hi[i] += int'(pwm_out[i]);
      end
      chk("R3/R5 ch0 high time", hi[0], VEC[v].e0);
      chk("R3/R6/R7 ch1 high time", hi[1], VEC[v].e1);
      chk("R4/R6/R7 ch2 high time", hi[2], VEC[v].e2);
      chk("R2/R4 ch3 high time", hi[3], VEC[v].e3);
    end

    // R8: reload lands only at the next wrap
    setup(0, 9, 2, 0, 0, 12, 'h55, 'h0);
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    while (pwm_out[0] !== 1'b0) @(negedge clk);
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd7;
    run1 = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (pwm_out[0] === 1'b1) begin run1++; @(negedge clk); end
    while (pwm_out[0] !== 1'b1) @(negedge clk);
    run2 = 0;
    while (pwm_out[0] === 1'b1) begin run2++; @(negedge clk); end
    chk("R8 old width kept in current period", run1, 2);
    chk("R8 new width after wrap", run2, 7);

    // R9: halt holds outputs
    repeat (5) @(negedge clk);
    wr(0, 1);
    snap = pwm_out;
    chk("R4 ch3 full duty before halt", int'(snap[3]), 1);
    repeat (40) @(negedge clk);
    chk("R9 outputs held while halted", int'(pwm_out), int'(snap));

    // R10: clear drives outputs low
    wr(0, 2);
    chk("R10 outputs low after clear", int'(pwm_out), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule